// File: doc/BRIEF.md
# OSD Dot Colour Mixer

This block sits at the end of an on-screen-display pixel pipeline. For every display dot it takes the decoded character dot, a flag that marks the dot as part of a character border, and a flag that marks the dot as lying inside the row's background box. From these it forms the final colour word and two overlay controls. `fbkg` tells the downstream video switch to replace the incoming picture with the OSD colour. `htone` requests a half-tone dimming of the picture behind the box.

Three controls apply to a whole text row: background enable, border enable and an FBKG-on-background select. The row sequencer presents them and pulses `row_load` once per row. The block latches them on that pulse, so they cannot change from one character to the next within a row. Foreground and background colours arrive with each dot. Every output is registered and changes on the clock edge that samples `pix_vld`. All outputs are active-high.

Top module: `osd_dot_mixer`

## Requirements
- R1: A synchronous reset drives `col_out`, `fbkg` and `htone` to 0 and clears the three latched row controls to 0.
- R2: Outputs are registered. A dot sampled with `pix_vld` high at a clock edge appears on the outputs right after that same edge.
- R3: A foreground dot (`dot_fg`=1) gives `col_out`=`fg_col`, `fbkg`=1 and `htone`=0, whatever the other dot flags and row controls are.
- R4: A border dot that is not a foreground dot, in a row whose latched border enable is 1, gives `col_out`=0, `fbkg`=1 and `htone`=0.
- R5: When the latched border enable is 0, `dot_border` has no effect. The dot is treated as a background dot or as an empty dot.
- R6: A background dot gives `col_out`=`bg_col` and `htone`=1. A background dot is one that is not foreground, not an active border, has `dot_bgreg`=1, and lies in a row whose latched background enable is 1. `htone` is 1 for no other kind of dot.
- R7: On a background dot, `fbkg` equals the row's latched FBKG select.
- R8: Any other dot with `pix_vld`=1 drives all outputs to 0.
- R9: While `pix_vld` is 0, all outputs hold their values.
- R10: The row controls are taken from `row_bg_en`, `row_brd_en` and `row_fbkg_sel` only on edges where `row_load`=1. Changes to these inputs at other times have no effect. A dot sampled on the same edge as a load still uses the previous row's controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_vld | input | 1 | Dot strobe; the outputs update on edges where it is high |
| row_load | input | 1 | Latches the three row controls |
| row_bg_en | input | 1 | Row background enable, to be latched |
| row_brd_en | input | 1 | Row border enable, to be latched |
| row_fbkg_sel | input | 1 | Row select for FBKG on background dots, to be latched |
| dot_fg | input | 1 | Current dot is a character foreground dot |
| dot_border | input | 1 | Current dot is a border dot |
| dot_bgreg | input | 1 | Current dot lies in the background region |
| fg_col | input | CW | Foreground colour word (default R,G,B,I from MSB to LSB) |
| bg_col | input | CW | Background colour word |
| col_out | output | CW | Registered dot colour |
| fbkg | output | 1 | Registered overlay (fast blanking) control |
| htone | output | 1 | Registered half-tone control |

## Verification
The bench builds the block with the default four-bit colour word, one bit each for R, G, B and I. With four bits, every colour bit can be told apart, so a swap between the foreground and background sources shows up in the checks. A directed pass walks each priority case under all combinations of the row controls. This includes a border flag arriving in a row whose border is disabled, and a row load that coincides with a dot. A long random pass follows. It changes the row inputs without loading them and mixes idle cycles, so the latching and the hold behaviour are exercised against the model on every clock.

// File: rtl/osd_dot_mixer.sv
module osd_dot_mixer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_vld,
  input  logic          row_load,
  input  logic          row_bg_en,
  input  logic          row_brd_en,
  input  logic          row_fbkg_sel,
  input  logic          dot_fg,
  input  logic          dot_border,
  input  logic          dot_bgreg,
  input  logic [CW-1:0] fg_col,
  input  logic [CW-1:0] bg_col,
  output logic [CW-1:0] col_out,
  output logic          fbkg,
  output logic          htone
);

  logic bg_q, brd_q, fsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bg_q   <= 1'b0;
      brd_q  <= 1'b0;
      fsel_q <= 1'b0;
    end else if (row_load) begin
      bg_q   <= row_bg_en;
      brd_q  <= row_brd_en;
      fsel_q <= row_fbkg_sel;
    end
  end

  logic sel_brd, sel_bg;
  logic [CW-1:0] nxt_col;
  logic nxt_fbkg;

  assign sel_brd  = !dot_fg && dot_border && brd_q;
  assign sel_bg   = !dot_fg && !sel_brd && dot_bgreg && bg_q;
  assign nxt_col  = dot_fg ? fg_col : (sel_bg ? bg_col : '0);
  assign nxt_fbkg = dot_fg || sel_brd || (sel_bg && fsel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_out <= '0;
      fbkg    <= 1'b0;
      htone   <= 1'b0;
    end else if (pix_vld) begin
      col_out <= nxt_col;
      fbkg    <= nxt_fbkg;
      htone   <= sel_bg;
    end
  end

endmodule

// File: rtl/osd_dot_mixer_chk.sv
module osd_dot_mixer_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_vld,
  input logic          dot_fg,
  input logic          dot_border,
  input logic          dot_bgreg,
  input logic [CW-1:0] fg_col,
  input logic [CW-1:0] bg_col,
  input logic          bg_q,
  input logic          brd_q,
  input logic          fsel_q,
  input logic [CW-1:0] col_out,
  input logic          fbkg,
  input logic          htone
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (col_out == '0 && !fbkg && !htone));

  a_r3_fg_wins: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && dot_fg) |=> (col_out == $past(fg_col) && fbkg && !htone));

  a_r4_border_dot: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && !dot_fg && dot_border && brd_q) |=> (col_out == '0 && fbkg && !htone));

  a_r6_r7_bg_dot: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && !dot_fg && !(dot_border && brd_q) && dot_bgreg && bg_q)
    |=> (col_out == $past(bg_col) && htone && fbkg == $past(fsel_q)));

  a_r8_empty_dot: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && !dot_fg && !(dot_border && brd_q) && !(dot_bgreg && bg_q))
    |=> (col_out == '0 && !fbkg && !htone));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_vld |=> ($stable(col_out) && $stable(fbkg) && $stable(htone)));

endmodule

bind osd_dot_mixer osd_dot_mixer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .pix_vld(pix_vld), .dot_fg(dot_fg),
  .dot_border(dot_border), .dot_bgreg(dot_bgreg), .fg_col(fg_col),
  .bg_col(bg_col), .bg_q(bg_q), .brd_q(brd_q), .fsel_q(fsel_q),
  .col_out(col_out), .fbkg(fbkg), .htone(htone)
);

// File: tb/test_osd_dot_mixer.sv
module test_osd_dot_mixer;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, pix_vld, row_load, row_bg_en, row_brd_en, row_fbkg_sel;
  logic dot_fg, dot_border, dot_bgreg;
  logic [CW-1:0] fg_col, bg_col, col_out;
  logic fbkg, htone;

  osd_dot_mixer #(.CW(CW)) i_osd_dot_mixer (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .row_load(row_load),
    .row_bg_en(row_bg_en), .row_brd_en(row_brd_en), .row_fbkg_sel(row_fbkg_sel),
    .dot_fg(dot_fg), .dot_border(dot_border), .dot_bgreg(dot_bgreg),
    .fg_col(fg_col), .bg_col(bg_col), .col_out(col_out), .fbkg(fbkg), .htone(htone)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  string phase = "";

  // behavioural reference
  bit m_bg, m_brd, m_fsel;
  logic [CW-1:0] e_col;
  bit e_fbkg, e_ht;
  string e_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_bg = 0; m_brd = 0; m_fsel = 0;
      e_col = '0; e_fbkg = 0; e_ht = 0; e_tag = "R1";
    end else begin
      if (pix_vld) begin
        if (dot_fg) begin
          e_col = fg_col; e_fbkg = 1; e_ht = 0; e_tag = "R3";
        end else if (dot_border && m_brd) begin
          e_col = '0; e_fbkg = 1; e_ht = 0; e_tag = "R4";
        end else if (dot_bgreg && m_bg) begin
          e_col = bg_col; e_fbkg = m_fsel; e_ht = 1;
          e_tag = dot_border ? "R5 R6 R7" : "R6 R7";
        end else begin
          e_col = '0; e_fbkg = 0; e_ht = 0;
          e_tag = dot_border ? "R5 R8" : "R8";
        end
      end else e_tag = "R9";
      if (row_load) begin
        m_bg = row_bg_en; m_brd = row_brd_en; m_fsel = row_fbkg_sel;
      end
    end
  end

  task automatic chk();
    checks++;
    if (col_out !== e_col || fbkg !== e_fbkg || htone !== e_ht) begin
      errors++;
      $display("FAIL %s R2 %s: got col=%h fbkg=%b htone=%b exp col=%h fbkg=%b htone=%b",
               e_tag, phase, col_out, fbkg, htone, e_col, e_fbkg, e_ht);
    end
  endtask

  task automatic px(input logic v, input logic f, input logic b, input logic g,
                    input logic [CW-1:0] fc, input logic [CW-1:0] bc);
    pix_vld = v; dot_fg = f; dot_border = b; dot_bgreg = g; fg_col = fc; bg_col = bc;
    @(negedge clk); chk();
  endtask

  task automatic ld(input logic bg, input logic brd, input logic fs);
    row_load = 1; row_bg_en = bg; row_brd_en = brd; row_fbkg_sel = fs; pix_vld = 0;
    @(negedge clk); chk();
    row_load = 0;
  endtask

  initial begin
    rst = 1; pix_vld = 0; row_load = 0; row_bg_en = 0; row_brd_en = 0; row_fbkg_sel = 0;
    dot_fg = 0; dot_border = 0; dot_bgreg = 0; fg_col = '0; bg_col = '0;
    repeat (3) begin @(negedge clk); chk(); end   // R1 reset state
    rst = 0;
    // R1: cleared row controls -> border/bg flags give an empty dot
    px(1, 0, 1, 1, 4'hA, 4'h5);
    for (int c = 0; c < 8; c++) begin
      ld(c[0], c[1], c[2]);
      px(1, 1, 1, 1, 4'hC, 4'h3);   // R3
      px(1, 0, 1, 1, 4'hC, 4'h3);   // R4 or R5
      px(1, 0, 1, 0, 4'h9, 4'h6);
      px(1, 0, 0, 1, 4'h9, 4'h6);   // R6 R7
      px(0, 1, 0, 0, 4'hF, 4'hF);   // R9 hold
      px(1, 0, 0, 0, 4'h7, 4'h8);   // R8
      px(0, 0, 0, 1, 4'h1, 4'h2);   // R9
    end
    // R10: row inputs change without a load
    phase = "R10";
    ld(1, 1, 1);
    row_bg_en = 0; row_brd_en = 0; row_fbkg_sel = 0;
    px(1, 0, 1, 1, 4'h2, 4'hD);
    px(1, 0, 0, 1, 4'h2, 4'hD);
    // R10: load in the same cycle as a dot; the dot uses the old controls
    row_load = 1;
    px(1, 0, 0, 1, 4'h4, 4'hB);
    row_load = 0;
    px(1, 0, 0, 1, 4'h4, 4'hB);
    // random pass
    phase = "rand";
    for (int n = 0; n < 4000; n++) begin
      row_load = ($urandom % 16) == 0;
      row_bg_en = $urandom; row_brd_en = $urandom; row_fbkg_sel = $urandom;
      px(($urandom % 4) != 0, ($urandom % 4) == 0, $urandom, $urandom, CW'($urandom), CW'($urandom));
    end
    row_load = 0;
    rst = 1;
    @(negedge clk); chk();   // R1 reset mid-run
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule